// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion-Count Registers

This block keeps the interrupt state of one DMA channel. Eight sticky event flags record single-cycle pulses from the transfer engine and the timeout timer. An eight-bit mask decides which of the flags may drive a single level interrupt line. Software never writes the mask directly. It sets mask bits through one write-only address and clears them through another. After reset the mask is all ones, so every source starts masked.

A three-bit counter keeps the number of completions that software has not yet handled. Each completion pulse increments it. Each software clear of the set completion flag decrements it. Software can also clear counter bits directly by writing ones to them. The status word also shows a busy bit, a FIFO level and an outstanding-command count. These come from the data path and are read-only.

Access is through a simple single-cycle register bus: a request with a write enable, a word index and write data. Read data is combinational from the word index.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset the flags are 0, the mask is 0xFF, the completion count is 0 and irq_o is low.
- R2: A high bit of evt_i sets the matching sticky flag, which is readable at word 1 on the next cycle. Flag order, MSB first: 7 FIFO overflow, 6 illegal bus access, 5 threshold hit, 4 memory timeout, 3 stream timeout, 2 bus response error, 1 completion, 0 memory completion.
- R3: A write to word 1 clears each flag whose wdata bit is 1. Flags whose wdata bit is 0 are unchanged.
- R4: An event on a bit in the same cycle as a software clear of that bit leaves the flag set.
- R5: Writing ones to word 2 clears those mask bits. Writing ones to word 3 sets those mask bits. Words 2 and 3 store nothing and read as 0.
- R6: The mask is read at word 4. A write to word 4 has no effect.
- R7: irq_o is high exactly when some flag is set whose mask bit is 0. It follows a flag or mask change one cycle after the write or event.
- R8: Each completion pulse (evt_i bit 1) adds one to the count in word 0 bits 15:13. The count wraps modulo 8.
- R9: A write to word 1 with bit 1 set, while the completion flag is set, subtracts one from the count. The same write has no effect on the count while the flag is clear.
- R10: A completion pulse and a decrementing clear in the same cycle leave the count unchanged.
- R11: Word 0 bit 0 is busy_i, bits 4:1 are outstanding_i and bits 12:5 are fifo_level_i. A write to word 0 clears the count bits that are 1 in wdata 15:13 and then applies any increment in the same cycle. Other bits of that write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| evt_i | input | 8 | Event pulses, one per flag |
| busy_i | input | 1 | Channel busy |
| fifo_level_i | input | 8 | FIFO fill level |
| outstanding_i | input | 4 | Outstanding commands |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: eight event sources and a three-bit counter. With a counter that narrow, nine completions in a row show the wrap from 7 to 0. A clear of the completion flag while it is already clear shows that the count does not underflow to 7. Collisions are driven deliberately: an event meeting a clear, a completion meeting a decrement, and a completion meeting a direct count clear. A behavioural model checks irq_o and the word being read on every cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    WORD_STATUS = 3'd0,
    WORD_FLAGS  = 3'd1,
    WORD_ENABLE = 3'd2,
    WORD_DISABLE= 3'd3,
    WORD_MASK   = 3'd4
  } word_e;

  localparam int unsigned DONE_BIT = 1;
endpackage

// File: rtl/dma_evt_flags.sv
module dma_evt_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] unmask_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= (mask_q & ~unmask_i) | mask_i;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/dma_done_cnt.sv
module dma_done_cnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, base, cnt_d;

  always_comb begin
    base  = cnt_q & ~clr_i;
    cnt_d = base;
    if (inc_i && !dec_i)      cnt_d = base + W'(1);
    else if (dec_i && !inc_i) cnt_d = base - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned N_EVT   = 8,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned FIFO_W  = 8,
  parameter int unsigned OUTST_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [N_EVT-1:0]    evt_i,
  input  logic                busy_i,
  input  logic [FIFO_W-1:0]   fifo_level_i,
  input  logic [OUTST_W-1:0]  outstanding_i,
  output logic                irq_o
);
  localparam int unsigned OUTST_LSB = 1;
  localparam int unsigned FIFO_LSB  = OUTST_LSB + OUTST_W;
  localparam int unsigned CNT_LSB   = FIFO_LSB + FIFO_W;
  localparam int unsigned CNT_MSB   = CNT_LSB + CNT_W - 1;

  logic wr;
  logic wr_status, wr_flags, wr_en, wr_dis;
  logic [N_EVT-1:0] flag_q, mask_q, flag_clr;
  logic [CNT_W-1:0] cnt_q, cnt_clr;
  logic done_dec;

  assign wr        = req_i & we_i;
  assign wr_status = wr && (addr_i == WORD_STATUS);
  assign wr_flags  = wr && (addr_i == WORD_FLAGS);
  assign wr_en     = wr && (addr_i == WORD_ENABLE);
  assign wr_dis    = wr && (addr_i == WORD_DISABLE);

  assign flag_clr = wr_flags ? wdata_i[N_EVT-1:0] : '0;
  assign cnt_clr  = wr_status ? wdata_i[CNT_MSB:CNT_LSB] : '0;
  assign done_dec = flag_clr[DONE_BIT] & flag_q[DONE_BIT];

  dma_evt_flags #(.N(N_EVT)) u_flags (
    .clk_i, .rst_ni,
    .set_i  (evt_i),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  dma_irq_mask #(.N(N_EVT)) u_mask (
    .clk_i, .rst_ni,
    .unmask_i (wr_en  ? wdata_i[N_EVT-1:0] : '0),
    .mask_i   (wr_dis ? wdata_i[N_EVT-1:0] : '0),
    .mask_o   (mask_q)
  );

  dma_done_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i (evt_i[DONE_BIT]),
    .dec_i (done_dec),
    .clr_i (cnt_clr),
    .cnt_o (cnt_q)
  );

  assign irq_o = |(flag_q & ~mask_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      WORD_STATUS: begin
        rdata_o[0]                     = busy_i;
        rdata_o[FIFO_LSB-1:OUTST_LSB]  = outstanding_i;
        rdata_o[CNT_LSB-1:FIFO_LSB]    = fifo_level_i;
        rdata_o[CNT_MSB:CNT_LSB]       = cnt_q;
      end
      WORD_FLAGS: rdata_o[N_EVT-1:0] = flag_q;
      WORD_MASK:  rdata_o[N_EVT-1:0] = mask_q;
      default:    rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:CNT_MSB+1], wdata_i[CNT_LSB-1:N_EVT]};
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk #(
  parameter int unsigned N_EVT = 8,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [N_EVT-1:0] evt_i,
  input logic             irq_o,
  input logic [N_EVT-1:0] flag_q,
  input logic [N_EVT-1:0] mask_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic wr_f, wr_e, wr_d, wr_s;
  assign wr_f = req_i && we_i && addr_i == 3'd1;
  assign wr_e = req_i && we_i && addr_i == 3'd2;
  assign wr_d = req_i && we_i && addr_i == 3'd3;
  assign wr_s = req_i && we_i && addr_i == 3'd0;

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  // R3
  clear_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_f |=> ((flag_q & $past(wdata_i[N_EVT-1:0]) & ~$past(evt_i)) == '0));
  // R5
  unmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_e |=> ((mask_q & $past(wdata_i[N_EVT-1:0])) == '0));
  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d |=> ((mask_q & $past(wdata_i[N_EVT-1:0])) == $past(wdata_i[N_EVT-1:0])));
  // R6
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_e || wr_d) |=> $stable(mask_q));
  // R7
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
  // R9
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_f && wdata_i[1] && flag_q[1] && !evt_i[1]) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_s && (evt_i[1] == (wr_f && wdata_i[1] && flag_q[1]))) |=> $stable(cnt_q));
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.N_EVT(N_EVT), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .evt_i(evt_i), .irq_o(irq_o),
  .flag_q(flag_q), .mask_q(mask_q), .cnt_q(cnt_q)
);

// File: tb/dma_irq_regs_bench.sv
module dma_irq_regs_bench;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] evt = 0;
  logic busy = 0;
  logic [7:0] fifo = 0;
  logic [3:0] outst = 0;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_irq_regs u_dma_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .busy_i(busy),
    .fifo_level_i(fifo), .outstanding_i(outst), .irq_o(irq)
  );

  // behavioural reference
  int m_flags, m_mask, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_mask = 255; m_cnt = 0;
    end else begin
      bit w; int inc, dec, c;
      w = req && we;
      inc = evt[1];
      dec = (w && addr == 1 && wdata[1] && m_flags[1]) ? 1 : 0;
      c = m_cnt;
      if (w && addr == 0) c = c & ~int'(wdata[15:13]);
      m_cnt = (c + inc + 8 - dec) % 8;
      if (w && addr == 1) m_flags = m_flags & ~int'(wdata[7:0]);
      m_flags = m_flags | int'(evt);
      if (w && addr == 2) m_mask = m_mask & ~int'(wdata[7:0]);
      if (w && addr == 3) m_mask = m_mask | int'(wdata[7:0]);
    end
  end

  function automatic int model_rd(int a);
    case (a)
      0: return (m_cnt << 13) | (int'(fifo) << 5) | (int'(outst) << 1) | int'(busy);
      1: return m_flags;
      4: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    check("R7 irq", int'(irq), ((m_flags & ~m_mask) != 0) ? 1 : 0);
    check("R11 rdata", int'(rdata), model_rd(int'(addr)));
  end

  task automatic cyc(bit w, int a, int d, int e);
    @(negedge clk); #1;
    req = w; we = w; addr = 3'(a); wdata = d; evt = 8'(e);
    @(negedge clk); #1;
    req = 0; we = 0; evt = 0; wdata = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    addr = 3'(a); #1;
    check(tag, int'(rdata), exp);
  endtask

  initial begin
    #100000;
    $display("FAIL watchdog: actual=running expected=finished");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk); #1;
    rd("R1 status", 0, 0); rd("R1 flags", 1, 0); rd("R1 mask", 4, 'hFF);
    check("R1 irq", int'(irq), 0);
    cyc(0, 0, 0, 'h81);
    rd("R2 flags", 1, 'h81); check("R7 masked irq", int'(irq), 0);
    cyc(1, 2, 1, 0);
    rd("R5 unmask", 4, 'hFE); check("R7 irq high", int'(irq), 1);
    rd("R5 enable word", 2, 0); rd("R5 disable word", 3, 0);
    cyc(1, 1, 0, 0); rd("R3 zero write", 1, 'h81);
    cyc(1, 1, 1, 0); rd("R3 clear", 1, 'h80); check("R7 irq low", int'(irq), 0);
    cyc(1, 1, 'h80, 'h80); rd("R4 collide", 1, 'h80);
    cyc(1, 1, 'h80, 0); rd("R3 clear7", 1, 0);
    cyc(1, 4, 0, 0); rd("R6 ro mask", 4, 'hFE);
    cyc(1, 3, 1, 0); rd("R5 disable", 4, 'hFF);
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 2);
    rd("R8 wrap", 0, 'h2000); rd("R8 flag", 1, 2);
    cyc(1, 1, 2, 0); rd("R9 dec", 0, 0);
    cyc(1, 1, 2, 0); rd("R9 no dec", 0, 0);
    cyc(0, 0, 0, 2); cyc(0, 0, 0, 2); rd("R8 two", 0, 'h4000);
    cyc(1, 1, 2, 2); rd("R10 cancel", 0, 'h4000); rd("R10 flag", 1, 2);
    cyc(1, 2, 2, 0); check("R7 done irq", int'(irq), 1);
    busy = 1; fifo = 'hA5; outst = 9;
    cyc(1, 0, 'h1FFF, 0); rd("R11 ro fields", 0, 'h54B3);
    cyc(1, 0, 'h2000, 0); rd("R11 clr bit0", 0, 'h54B3);
    cyc(1, 0, 'h4000, 0); rd("R11 clr bit1", 0, 'h14B3);
    cyc(1, 0, 'hE000, 2); rd("R11 clr+inc", 0, 'h34B3);
    rst_n = 0; #1;
    rd("R1 async mask", 4, 'hFF); rd("R1 async flags", 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule